// File: doc/BRIEF.md
# DMA Channel Trigger Controller

This block decides when one DMA channel is allowed to move data. It watches an external trigger line, qualifies it by a programmable sense (rising or falling edge, high or low level), and on each qualified event asks a downstream data mover for either a single transfer or a burst of 2^P transfers. A peripheral request line can also be enabled to pace the channel. When it is enabled, each individual transfer is held back until the peripheral asserts that line.

Transfers are requested one at a time through a request/acknowledge handshake. The block tracks how many transfers remain in the current unit of work. It raises a busy flag while work is outstanding and gives a one-cycle done pulse when the last transfer has been acknowledged. With the trigger disabled, the channel is started from a start input instead.

Top module: `dma_trig_ctrl`

## Requirements
- R1: While reset is held and after it is released with no stimulus, `xfer_req_o`, `busy_o` and `burst_done_o` are low.
- R2: The configuration word has these fields: bit 0 pace enable, bit 1 trigger enable, bit 2 polarity, bit 3 level mode, bit 4 burst, bits 8:5 burst power P. With bit 4 clear, a unit of work is one transfer. With bit 4 set, it is 2^P transfers, and a P above 10 acts as 10 (1024 transfers).
- R3: With bit 1 clear, the trigger input has no effect and a one-cycle pulse on `sw_start_i` launches a unit of work. With bit 1 set, `sw_start_i` has no effect.
- R4: Edge mode is selected by bit 3 = 0. With bit 2 = 1 a rising edge of the trigger launches a unit of work; with bit 2 = 0 a falling edge does. The opposite edge does nothing, and a level held after the edge does not launch again.
- R5: In edge mode, any number of active edges that arrive while the channel is busy collapse into one pending event, which launches exactly one more unit of work once the current one finishes.
- R6: Level mode is selected by bit 3 = 1. When the channel is idle and the trigger is at its active level (high when bit 2 = 1, low when bit 2 = 0), a unit of work is launched, and this repeats after each completion while the level stays active. An inactive level never launches.
- R7: With bit 0 set, a transfer request is raised only while `preq_i` is high. A launched channel with `preq_i` low stays busy and issues no request.
- R8: `xfer_req_o` stays high until a cycle in which `xfer_ack_i` is high; it is low in the following cycle. At most one request is outstanding.
- R9: `burst_done_o` is high for exactly one cycle, in the cycle after the clock edge that took the last acknowledge of a unit, and `busy_o` is low in that same cycle.
- R10: The latency is counted in clock edges. A start pulse sampled at an edge sets `busy_o` after that edge. A trigger change lands on the first of three edges and sets `busy_o` after the third. `xfer_req_o` rises one edge after `busy_o` when pacing allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 9 | Channel configuration word (fields in R2) |
| sw_start_i | input | 1 | Start pulse used when the trigger is disabled |
| trig_i | input | 1 | Asynchronous hardware trigger |
| preq_i | input | 1 | Peripheral request used for pacing |
| xfer_ack_i | input | 1 | Transfer acknowledge from the data mover |
| xfer_req_o | output | 1 | Transfer request to the data mover |
| busy_o | output | 1 | A unit of work is in progress |
| burst_done_o | output | 1 | One-cycle pulse when a unit of work completes |

## Verification
Each result has a fixed position in time. After a start pulse, busy is due right after the sampling edge. After a trigger change, busy is due after the third edge, because of the two synchronizer flops plus the launch register. A request is due one edge after busy, and done is due one edge after the final acknowledge. The bench drives and samples on the falling clock edge, so it checks busy exactly at the second and third falling edges after a trigger change and at the first after a start. Burst lengths are checked at each done pulse against the queue of expected counts. Any done pulse that arrives when the queue is empty is reported.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int CFG_W = 9;
  localparam int PWR_W = 4;

  typedef struct packed {
    logic [PWR_W-1:0] pwr;
    logic             burst;
    logic             level;
    logic             pol_high;
    logic             trig_en;
    logic             pace_en;
  } chan_cfg_t;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) sh_q[i] <= sh_q[i-1];
    end
  end

  assign q_o      = sh_q[STAGES-1];
  assign q_prev_o = sh_q[STAGES];
endmodule

// File: rtl/dtc_trig_qual.sv
module dtc_trig_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_s_i,
  input  logic trig_p_i,
  input  logic trig_en_i,
  input  logic pol_high_i,
  input  logic level_i,
  input  logic start_i,
  input  logic idle_i,
  output logic launch_o
);
  logic act, act_prev, edge_hit, edge_mode, pend_q, evt;

  assign act       = pol_high_i ? trig_s_i : ~trig_s_i;
  assign act_prev  = pol_high_i ? trig_p_i : ~trig_p_i;
  assign edge_hit  = act & ~act_prev;
  assign edge_mode = trig_en_i & ~level_i;

  always_comb begin
    if (!trig_en_i)   evt = start_i;
    else if (level_i) evt = act;
    else              evt = edge_hit | pend_q;
  end

  assign launch_o = idle_i & evt;

  // edges seen while busy fold into one pending event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= 1'b0;
    else if (!edge_mode)           pend_q <= 1'b0;
    else if (launch_o)             pend_q <= 1'b0;
    else if (edge_hit && !idle_i)  pend_q <= 1'b1;
  end
endmodule

// File: rtl/dtc_burst_seq.sv
module dtc_burst_seq #(
  parameter int MAX_PWR = 10,
  parameter int PWR_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             burst_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic             pace_en_i,
  input  logic             pace_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = MAX_PWR + 1;
  localparam logic [PWR_W-1:0] MAX_P = PWR_W'(MAX_PWR);

  logic [PWR_W-1:0] pwr_eff;
  logic [CNT_W-1:0] len, rem_q;
  logic             req_q, busy_q, done_q, pace_ok;

  assign pwr_eff = (pwr_i > MAX_P) ? MAX_P : pwr_i;
  assign len     = burst_i ? (CNT_W'(1) << pwr_eff) : CNT_W'(1);
  assign pace_ok = ~pace_en_i | pace_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_i) begin
        busy_q <= 1'b1;
        rem_q  <= len;
        req_q  <= 1'b0;
      end else if (busy_q) begin
        if (req_q && ack_i) begin
          req_q <= 1'b0;
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else if (!req_q && pace_ok) begin
          req_q <= 1'b1;
        end
      end
    end
  end

  assign req_o  = req_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl #(
  parameter int MAX_PWR     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [dtc_pkg::CFG_W-1:0] cfg_i,
  input  logic                      sw_start_i,
  input  logic                      trig_i,
  input  logic                      preq_i,
  input  logic                      xfer_ack_i,
  output logic                      xfer_req_o,
  output logic                      busy_o,
  output logic                      burst_done_o
);
  import dtc_pkg::*;

  chan_cfg_t cfg;
  logic      trig_s, trig_p, launch, busy;

  assign cfg = chan_cfg_t'(cfg_i);

  dtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (trig_i),
    .q_o      (trig_s),
    .q_prev_o (trig_p)
  );

  dtc_trig_qual u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_s_i   (trig_s),
    .trig_p_i   (trig_p),
    .trig_en_i  (cfg.trig_en),
    .pol_high_i (cfg.pol_high),
    .level_i    (cfg.level),
    .start_i    (sw_start_i),
    .idle_i     (~busy),
    .launch_o   (launch)
  );

  dtc_burst_seq #(.MAX_PWR(MAX_PWR), .PWR_W(PWR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .burst_i   (cfg.burst),
    .pwr_i     (cfg.pwr),
    .pace_en_i (cfg.pace_en),
    .pace_i    (preq_i),
    .ack_i     (xfer_ack_i),
    .req_o     (xfer_req_o),
    .busy_o    (busy),
    .done_o    (burst_done_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pace_en_i,
  input logic trig_en_i,
  input logic start_i,
  input logic preq_i,
  input logic ack_i,
  input logic req_i,
  input logic busy_i,
  input logic done_i
);
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_i |=> req_i);
  p_req_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ack_i |=> !req_i);
  p_req_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> busy_i);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);
  p_done_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(req_i && ack_i));
  p_pace_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) && $past(pace_en_i) |-> $past(preq_i));
  p_sw_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) && !$past(trig_en_i) |-> $past(start_i));
endmodule

bind dma_trig_ctrl dtc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pace_en_i (cfg_i[0]),
  .trig_en_i (cfg_i[1]),
  .start_i   (sw_start_i),
  .preq_i    (preq_i),
  .ack_i     (xfer_ack_i),
  .req_i     (xfer_req_o),
  .busy_i    (busy_o),
  .done_i    (burst_done_o)
);

// File: tb/sim_dma_trig_ctrl.sv
module sim_dma_trig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cfg = '0;
  logic       start = 1'b0, trig = 1'b0, preq = 1'b0, ack = 1'b0;
  logic       req, busy, done;
  logic       ack_en = 1'b1;

  int total = 0, bad = 0;
  int exp_q[$];
  int acks_in = 0, done_cnt = 0, stall = 0, stall_len = 0;
  logic prev_req = 1'b0, prev_done = 1'b0, had_ack;

  always #4 clk = ~clk;

  dma_trig_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .sw_start_i(start),
    .trig_i(trig), .preq_i(preq), .xfer_ack_i(ack),
    .xfer_req_o(req), .busy_o(busy), .burst_done_o(done)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [8:0] mk(input bit pc, input bit te, input bit pol,
                                    input bit lvl, input bit bu, input int p);
    return {p[3:0], bu, lvl, pol, te, pc};
  endfunction

  // monitor: acts as data mover and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      had_ack = ack;
      if (had_ack) begin
        ack = 1'b0;
        acks_in++;
        stall_len = (stall_len + 1) % 3;
        stall = stall_len;
        if (req) chk(1'b0, "R8 req drops after ack", req, 0);
      end else if (prev_req && !req) begin
        chk(1'b0, "R8 req held until ack", req, 1);
      end
      if (done) begin
        done_cnt++;
        chk(!busy, "R9 busy low with done", busy, 0);
        chk(!prev_done, "R9 done one cycle", prev_done, 0);
        chk(had_ack, "R9 done after last ack", had_ack, 1);
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected burst", acks_in, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(acks_in == e, "R2 burst length", acks_in, e);
        end
        acks_in = 0;
      end
      if (!had_ack && req && ack_en) begin
        if (stall == 0) ack = 1'b1;
        else stall--;
      end
      prev_req = req;
      prev_done = done;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic drain(input string rq);
    int n = 0;
    while ((exp_q.size() != 0 || busy) && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 6000, {rq, " completes"}, n, 0);
    repeat (12) @(negedge clk);
    chk(!busy && exp_q.size() == 0, {rq, " no extra work"}, busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    bit ok;
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done, "R1 outputs low in reset", {req, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req && !busy && !done, "R1 outputs low after reset", {req, busy, done}, 0);

    // R2/R3/R10 software start, single with power field ignored
    cfg = mk(0, 0, 0, 0, 0, 5);
    exp_q.push_back(1);
    pulse_start();
    chk(busy, "R10 busy one edge after start", busy, 1);
    @(negedge clk);
    chk(req, "R10 req one edge after busy", req, 1);
    drain("R3 start single");

    cfg = mk(0, 0, 0, 0, 1, 0); exp_q.push_back(1);    pulse_start(); drain("R2 P0");
    cfg = mk(0, 0, 0, 0, 1, 3); exp_q.push_back(8);    pulse_start(); drain("R2 P3");
    cfg = mk(0, 0, 0, 0, 1, 10); exp_q.push_back(1024); pulse_start(); drain("R2 P10");
    cfg = mk(0, 0, 0, 0, 1, 13); exp_q.push_back(1024); pulse_start(); drain("R2 P13 clamp");

    // R3 trigger ignored when disabled
    cfg = mk(0, 0, 1, 0, 1, 2);
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) trig = ~trig;
      repeat (4) begin @(negedge clk); if (busy) ok = 1'b0; end
    end
    chk(ok, "R3 trigger ignored", !ok, 0);

    // R3 start ignored with trigger enabled
    cfg = mk(0, 1, 1, 0, 0, 0);
    pulse_start();
    repeat (6) @(negedge clk);
    chk(!busy, "R3 start ignored", busy, 0);

    // R4 rising edge, with R10 latency
    cfg = mk(0, 1, 1, 0, 1, 2);
    exp_q.push_back(4);
    @(negedge clk) trig = 1'b1;
    @(negedge clk) chk(!busy, "R10 no busy after first edge", busy, 0);
    @(negedge clk) chk(!busy, "R10 no busy after second edge", busy, 0);
    @(negedge clk) chk(busy, "R10 busy after third edge", busy, 1);
    drain("R4 rising held once");
    @(negedge clk) trig = 1'b0;
    repeat (8) @(negedge clk);
    chk(!busy, "R4 falling ignored when rising", busy, 0);

    // R4 falling edge
    cfg = mk(0, 1, 0, 0, 1, 2);
    @(negedge clk) trig = 1'b1;
    repeat (8) @(negedge clk);
    chk(!busy, "R4 rising ignored when falling", busy, 0);
    exp_q.push_back(4);
    @(negedge clk) trig = 1'b0;
    drain("R4 falling");

    // R5 pending edges collapse
    cfg = mk(0, 1, 1, 0, 1, 4);
    exp_q.push_back(16); exp_q.push_back(16);
    base = done_cnt;
    @(negedge clk) trig = 1'b1;
    repeat (5) @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk); trig = 1'b1;
    repeat (3) @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk); trig = 1'b1;
    repeat (3) @(negedge clk); trig = 1'b0;
    drain("R5 pending");
    chk(done_cnt - base == 2, "R5 two bursts", done_cnt - base, 2);

    // R6 level mode, active low
    cfg = mk(0, 0, 0, 0, 0, 0);
    @(negedge clk) trig = 1'b1;
    repeat (4) @(negedge clk);
    cfg = mk(0, 1, 0, 1, 0, 0);
    repeat (10) @(negedge clk);
    chk(!busy, "R6 inactive level", busy, 0);
    repeat (4) exp_q.push_back(1);
    base = done_cnt;
    @(negedge clk) trig = 1'b0;
    while (done_cnt < base + 3) @(posedge clk);
    @(negedge clk);
    ack_en = 1'b0;
    trig = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy && req, "R8 req held without ack", {busy, req}, 3);
    ack_en = 1'b1;
    drain("R6 level repeat");
    chk(done_cnt - base == 4, "R6 repeat count", done_cnt - base, 4);

    // R7 pacing
    cfg = mk(1, 0, 0, 0, 1, 1);
    preq = 1'b0;
    exp_q.push_back(2);
    pulse_start();
    repeat (10) @(negedge clk);
    chk(busy && !req, "R7 no req while preq low", {busy, req}, 2);
    preq = 1'b1;
    drain("R7 paced burst");
    preq = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule